// File: doc/BRIEF.md
# Security interrupt status aggregator

This block is a secure-side register set. It gathers level interrupt signals from three kinds of controller: peripheral protection controllers (PPC), memory protection controllers (MPC) and master security controllers (MSC). Each input is registered into a status word at a fixed, sparse bit position. Software reads these words over a 32-bit register port.

For the PPCs, an enable register is split back out into one enable line per controller group. A clear register sends a one-cycle clear pulse to each group whose bit is written as one.

For the MSCs, a status bit combined with its enable bit raises a single merged interrupt. A clear register pulses the per-controller clear lines, and a separate register holds one non-secure control level per controller.

Two small configuration values, the non-secure-callable setting and the secure-response setting, are held in registers and driven straight out. A bridge enable register is stored. The bridge status always reads as zero.

The register port takes a write strobe with an access size, a word address and write data. Read data is combinational from the address. Only full 32-bit writes take effect.

Top module: `sec_irq_hub`

## Requirements
- R1: After reset, every enable, clear, non-secure, configuration and combined interrupt output is low, and every register reads zero.
- R2: The PPC status word (offset 0x20) shows, one clock after the inputs are sampled: internal group 0 at bit 0, internal group 1 at bit 1, APB expansion i at bit 4+i, AHB expansion i at bit 20+i. All other bits are zero.
- R3: The PPC enable register (0x28) keeps only the bits in mask 0x00F000F3. Each group's enable output follows its bit, at the same positions as R2.
- R4: A write to the PPC clear register (0x24) raises, for exactly the one cycle after the write edge, the clear output of each group whose bit (R2 positions) is one. The register reads zero.
- R5: The MPC status word (0x1C) holds the internal controller at bit 0 and expansion controller n at bit 16+n.
- R6: The MSC status word (0x30) holds expansion controller n at bit 16+n. The enable register (0x38) stores all 32 bits. The combined MSC interrupt is high exactly when some status bit and its enable bit are both one.
- R7: A write to the MSC clear register (0x34) pulses clear output i for one cycle from bit 16+i of the written data. The register reads zero.
- R8: The MSC non-secure register (0x4C) drives non-secure output i as a level from bit 16+i. It reads back those bits only.
- R9: The non-secure-callable register (0x14) keeps bits [1:0] and drives them out. The response register (0x10) keeps bit 0 and drives it out.
- R10: The bridge enable register (0x48) keeps bits [31:16]. Bridge status (0x40) reads zero. Writes to bridge clear (0x44) change nothing.
- R11: Writes to any status register are ignored. Writes with a size other than a 32-bit word (size code 2; 0 is byte, 1 is halfword) are ignored.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ppc_irq_i | input | N_APBX+N_AHBX+2 | PPC levels: internal 0, internal 1, APB expansions, AHB expansions |
| mpc_irq_i | input | 1 | Internal MPC level |
| mpcx_irq_i | input | N_MPCX | Expansion MPC levels |
| msc_irq_i | input | N_MSCX | Expansion MSC levels |
| ppc_en_o | output | N_APBX+N_AHBX+2 | Per-group PPC interrupt enable |
| ppc_clr_o | output | N_APBX+N_AHBX+2 | Per-group PPC clear pulse |
| msc_clr_o | output | N_MSCX | Per-controller MSC clear pulse |
| msc_ns_o | output | N_MSCX | Per-controller MSC non-secure level |
| msc_irq_o | output | 1 | Combined MSC interrupt |
| nsc_cfg_o | output | 2 | Non-secure-callable configuration |
| resp_cfg_o | output | 1 | Secure-response configuration |

## Verification
The block's results fall due at different times after a stimulus:

- **Status words:** an input level shows in the status words, and in the combined MSC interrupt, one rising edge after it is applied.
- **Register writes:** a write updates the enable, non-secure and configuration outputs at the rising edge that takes it. The clear outputs are high only between that edge and the next one.
- **Reads:** read data follows the address within the same cycle.

The bench drives stimulus and samples results at falling edges. It checks each clear output at the first falling edge after the write, and again one edge later to confirm it has returned to zero.

// File: rtl/sec_irq_hub.sv
module sec_irq_hub #(
  parameter int N_APBX = 4,
  parameter int N_AHBX = 4,
  parameter int N_MPCX = 4,
  parameter int N_MSCX = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_size,
  input  logic [11:0]              reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [N_APBX+N_AHBX+1:0] ppc_irq_i,
  input  logic                     mpc_irq_i,
  input  logic [N_MPCX-1:0]        mpcx_irq_i,
  input  logic [N_MSCX-1:0]        msc_irq_i,
  output logic [N_APBX+N_AHBX+1:0] ppc_en_o,
  output logic [N_APBX+N_AHBX+1:0] ppc_clr_o,
  output logic [N_MSCX-1:0]        msc_clr_o,
  output logic [N_MSCX-1:0]        msc_ns_o,
  output logic                     msc_irq_o,
  output logic [1:0]               nsc_cfg_o,
  output logic                     resp_cfg_o
);
  localparam int NPPC = N_APBX + N_AHBX + 2;
  localparam logic [11:0] A_RESP = 12'h010, A_NSC = 12'h014, A_MPC_ST = 12'h01C,
    A_PPC_ST = 12'h020, A_PPC_CLR = 12'h024, A_PPC_EN = 12'h028,
    A_MSC_ST = 12'h030, A_MSC_CLR = 12'h034, A_MSC_EN = 12'h038,
    A_BRG_ST = 12'h040, A_BRG_CLR = 12'h044, A_BRG_EN = 12'h048, A_MSC_NS = 12'h04C;

  function automatic int ppc_pos(int p);
    if (p < 2) return p;
    if (p < 2 + N_APBX) return 4 + p - 2;
    return 20 + p - 2 - N_APBX;
  endfunction

  function automatic logic [31:0] ppc_mask_f();
    logic [31:0] m = '0;
    for (int p = 0; p < NPPC; p++) m[ppc_pos(p)] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] PPC_MASK = ppc_mask_f();

  logic [11:0] waddr;
  logic        wr_ok;
  logic [31:0] ppc_vec, mpc_vec, msc_vec;
  logic [31:0] ppc_st_q, mpc_st_q, msc_st_q, ppc_en_q, msc_en_q, ppc_clr_q;
  logic [N_MSCX-1:0] msc_clr_q, msc_ns_q;
  logic [15:0] brg_en_q;
  logic [1:0]  nsc_q;
  logic        resp_q;

  assign waddr = {reg_addr[11:2], 2'b00};
  assign wr_ok = reg_wr && (reg_size == 2'd2);

  always_comb begin
    ppc_vec = '0;
    for (int p = 0; p < NPPC; p++) ppc_vec[ppc_pos(p)] = ppc_irq_i[p];
  end
  assign mpc_vec = (32'(mpcx_irq_i) << 16) | 32'(mpc_irq_i);
  assign msc_vec = 32'(msc_irq_i) << 16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppc_st_q <= '0; mpc_st_q <= '0; msc_st_q <= '0;
      ppc_en_q <= '0; msc_en_q <= '0; ppc_clr_q <= '0;
      msc_clr_q <= '0; msc_ns_q <= '0; brg_en_q <= '0;
      nsc_q <= '0; resp_q <= 1'b0;
    end else begin
      ppc_st_q  <= ppc_vec;
      mpc_st_q  <= mpc_vec;
      msc_st_q  <= msc_vec;
      ppc_clr_q <= '0;
      msc_clr_q <= '0;
      if (wr_ok) begin
        case (waddr)
          A_RESP:    resp_q    <= reg_wdata[0];
          A_NSC:     nsc_q     <= reg_wdata[1:0];
          A_PPC_CLR: ppc_clr_q <= reg_wdata & PPC_MASK;
          A_PPC_EN:  ppc_en_q  <= reg_wdata & PPC_MASK;
          A_MSC_CLR: msc_clr_q <= reg_wdata[16 +: N_MSCX];
          A_MSC_EN:  msc_en_q  <= reg_wdata;
          A_BRG_EN:  brg_en_q  <= reg_wdata[31:16];
          A_MSC_NS:  msc_ns_q  <= reg_wdata[16 +: N_MSCX];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPPC; p++) begin
      ppc_en_o[p]  = ppc_en_q[ppc_pos(p)];
      ppc_clr_o[p] = ppc_clr_q[ppc_pos(p)];
    end
  end

  assign msc_clr_o  = msc_clr_q;
  assign msc_ns_o   = msc_ns_q;
  assign msc_irq_o  = |(msc_st_q & msc_en_q);
  assign nsc_cfg_o  = nsc_q;
  assign resp_cfg_o = resp_q;

  always_comb begin
    case ({reg_addr[11:2], 2'b00})
      A_RESP:   reg_rdata = 32'(resp_q);
      A_NSC:    reg_rdata = 32'(nsc_q);
      A_MPC_ST: reg_rdata = mpc_st_q;
      A_PPC_ST: reg_rdata = ppc_st_q;
      A_PPC_EN: reg_rdata = ppc_en_q;
      A_MSC_ST: reg_rdata = msc_st_q;
      A_MSC_EN: reg_rdata = msc_en_q;
      A_BRG_EN: reg_rdata = {brg_en_q, 16'h0};
      A_MSC_NS: reg_rdata = 32'(msc_ns_q) << 16;
      default:  reg_rdata = '0;
    endcase
  end

  // R4
  ppc_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppc_clr_o != '0) |-> $past(wr_ok && waddr == A_PPC_CLR));

  // R7
  msc_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msc_clr_o != '0) |-> $past(wr_ok && waddr == A_MSC_CLR));

  // R6
  msc_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msc_irq_o |-> $past(msc_irq_i != '0));

  // R11
  narrow_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_size != 2'd2) |=> ($stable(ppc_en_o) && $stable(msc_ns_o) && $stable(nsc_cfg_o) && $stable(resp_cfg_o)));

  // R3
  ppc_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && waddr == A_PPC_EN) |=> $stable(ppc_en_o));
endmodule

// File: tb/tb_sec_irq_hub.sv
module tb_sec_irq_hub;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_size = 2;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [9:0] ppc_irq_i = 0, ppc_en_o, ppc_clr_o;
  logic mpc_irq_i = 0;
  logic [3:0] mpcx_irq_i = 0, msc_irq_i = 0, msc_clr_o, msc_ns_o;
  logic msc_irq_o, resp_cfg_o;
  logic [1:0] nsc_cfg_o;
  int checks = 0, errors = 0;
  bit done = 0;

  sec_irq_hub dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] ppc_map(logic [9:0] v);
    logic [31:0] r = '0;
    r[1:0] = v[1:0];
    for (int i = 0; i < 4; i++) begin r[4+i] = v[2+i]; r[20+i] = v[6+i]; end
    return r;
  endfunction

  function automatic logic [9:0] ppc_fan(logic [31:0] w);
    logic [9:0] r;
    r[1:0] = w[1:0];
    for (int i = 0; i < 4; i++) begin r[2+i] = w[4+i]; r[6+i] = w[20+i]; end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_wr = 0; reg_size = 2;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, en, msc_en, e_ppc, e_mpc, e_msc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 en", 32'(ppc_en_o), 0);
    check("R1 clr", 32'(ppc_clr_o) | 32'(msc_clr_o) | 32'(msc_ns_o), 0);
    check("R1 cfg", {29'd0, msc_irq_o, nsc_cfg_o} | 32'(resp_cfg_o), 0);
    for (int a = 'h10; a <= 'h4C; a += 4) begin rd(12'(a), d); check("R1 read", d, 0); end

    msc_en = 0;
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      ppc_irq_i = 10'($urandom); mpc_irq_i = 1'($urandom);
      mpcx_irq_i = 4'($urandom); msc_irq_i = 4'($urandom);
      e_ppc = ppc_map(ppc_irq_i);
      e_mpc = (32'(mpcx_irq_i) << 16) | 32'(mpc_irq_i);
      e_msc = 32'(msc_irq_i) << 16;
      @(negedge clk);
      rd(12'h020, d); check("R2 ppc status", d, e_ppc);
      rd(12'h01C, d); check("R5 mpc status", d, e_mpc);
      rd(12'h030, d); check("R6 msc status", d, e_msc);
      en = $urandom;
      wr(12'h028, en);
      rd(12'h028, d); check("R3 ppc enable read", d, en & 32'h00F000F3);
      check("R3 ppc enable out", 32'(ppc_en_o), 32'(ppc_fan(en)));
      msc_en = (it % 5 == 0) ? 32'h0 : $urandom;
      wr(12'h038, msc_en);
      rd(12'h038, d); check("R6 msc enable read", d, msc_en);
      check("R6 msc irq", 32'(msc_irq_o), 32'(|(e_msc & msc_en)));
      // R11 status write ignored
      wr(12'h020, 32'hFFFFFFFF);
      rd(12'h020, d); check("R11 status write", d, e_ppc);
    end

    // R6 directed: single matching bit, then disabled
    @(negedge clk); msc_irq_i = 4'b0100; @(negedge clk);
    wr(12'h038, 32'h0004_0000); check("R6 one bit", 32'(msc_irq_o), 1);
    wr(12'h038, 32'hFFFB_FFFF); check("R6 masked", 32'(msc_irq_o), 0);
    wr(12'h030, 32'hFFFFFFFF); rd(12'h030, d); check("R11 msc status write", d, 32'h0004_0000);

    // R4 clear pulses
    for (int k = 0; k < 4; k++) begin
      d = (k == 0) ? 32'hFFFFFFFF : $urandom;
      wr(12'h024, d);
      check("R4 clr pulse", 32'(ppc_clr_o), 32'(ppc_fan(d)));
      rd(12'h024, en); check("R4 clr read", en, 0);
      @(negedge clk); check("R4 clr end", 32'(ppc_clr_o), 0);
    end

    // R7 msc clear
    wr(12'h034, 32'h000A_FFFF);
    check("R7 msc clr pulse", 32'(msc_clr_o), 32'hA);
    @(negedge clk); check("R7 msc clr end", 32'(msc_clr_o), 0);
    rd(12'h034, d); check("R7 clr read", d, 0);

    // R8 msc non-secure
    wr(12'h04C, 32'h0005_FFFF);
    check("R8 ns out", 32'(msc_ns_o), 32'h5);
    rd(12'h04C, d); check("R8 ns read", d, 32'h0005_0000);
    repeat (2) @(negedge clk); check("R8 ns level", 32'(msc_ns_o), 32'h5);

    // R9 configuration
    wr(12'h014, 32'hFFFF_FFFE);
    check("R9 nsc out", 32'(nsc_cfg_o), 2);
    rd(12'h014, d); check("R9 nsc read", d, 2);
    wr(12'h010, 32'hFFFF_FFFF);
    check("R9 resp out", 32'(resp_cfg_o), 1);
    rd(12'h010, d); check("R9 resp read", d, 1);

    // R10 bridge
    wr(12'h048, 32'h1234_5678);
    rd(12'h048, d); check("R10 brg en", d, 32'h1234_0000);
    wr(12'h044, 32'hFFFFFFFF);
    rd(12'h048, d); check("R10 brg clr no effect", d, 32'h1234_0000);
    rd(12'h040, d); check("R10 brg status", d, 0);

    // R11 narrow writes ignored
    wr(12'h028, 32'h0000_0003);
    wr(12'h028, 32'h00F0_00F0, 2'd0);
    wr(12'h028, 32'h00F0_00F0, 2'd1);
    check("R11 narrow en out", 32'(ppc_en_o), 32'h3);
    rd(12'h028, d); check("R11 narrow en read", d, 32'h3);
    wr(12'h014, 32'h1, 2'd1);
    check("R11 narrow nsc", 32'(nsc_cfg_o), 2);
    wr(12'h024, 32'hFFFFFFFF, 2'd0);
    check("R11 narrow clr", 32'(ppc_clr_o), 0);

    // R12 unmapped
    rd(12'h100, d); check("R12 unmapped", d, 0);
    rd(12'h018, d); check("R12 gap", d, 0);
    rd(12'hFFC, d); check("R12 top", d, 0);

    finish_run();
  end
endmodule